// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when the outputs of a differential clock fan-out buffer may be switched on, and when it may report that it has settled. Four analog or neighbouring blocks feed it: a supply detector, a reference-clock activity detector, the PLL, and the board's active-low power-down pin. It returns an output-enable for the output drivers and a latched lock indication for downstream buffers that wait on this one.

After the supply comes up, the sequencer counts a fixed number of strobes from a slow timebase so that bias and references can settle. It then waits until a reference clock is present, power-down is released, and the PLL reports lock. In bypass mode the PLL is not in the path, so a present reference clock is enough. On entry to the running state both outputs rise together. The lock indication then stays high whatever the PLL reports, until power-down is asserted or the supply is lost. Power-down sends the sequencer back to the waiting state without a new settling delay. Loss of supply sends it back to the start.

All level inputs come from other clock domains or from pins, so each one passes through a synchronizer of `SYNC_STAGES` flops before the state machine sees it. The timebase strobe is a one-cycle pulse in the local clock domain.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While reset is low, and in the cycles after reset until the supply is seen, `out_en` and `lock_out` are 0.
- R2: After `supply_ok` rises, `out_en` stays 0 until at least `SETTLE_TICKS` pulses of `tick` have been counted, even when every other input would allow enabling.
- R3: After the settling delay, `out_en` rises only when `ref_present` is 1, `pd_n` is 1, and `pll_locked` is 1 (with `bypass` at 0).
- R4: With `ref_present` at 0, `out_en` stays 0, even when the supply is good, `pd_n` is 1 and the PLL reports lock.
- R5: With `bypass` at 1, `pll_locked` is not needed: a present reference clock and `pd_n` at 1 are enough to enable. A missing reference clock still keeps the outputs off.
- R6: `lock_out` rises in the same cycle as `out_en`, and it is never 1 while `out_en` is 0.
- R7: Once `lock_out` is 1, it stays 1 when `pll_locked` later drops, as long as the supply stays good and `pd_n` stays 1.
- R8: `pd_n` going to 0 while running clears both outputs. When `pd_n` returns to 1 and the other conditions hold, the outputs come back within a few cycles, with no new settling delay.
- R9: `supply_ok` going to 0 in any state clears both outputs. The next rise of `supply_ok` starts a full settling delay again, and a drop during settling restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the slow settling timebase |
| supply_ok | input | 1 | Supply detector reports a valid supply (asynchronous) |
| ref_present | input | 1 | Reference clock detected on the input (asynchronous) |
| pd_n | input | 1 | Power-down request, active low (asynchronous) |
| pll_locked | input | 1 | PLL lock detector (asynchronous) |
| bypass | input | 1 | 1 selects fan-out without the PLL (asynchronous) |
| out_en | output | 1 | Clock outputs may be driven |
| lock_out | output | 1 | Latched lock indication |

## Verification
The state is visible at the ports only through `out_en` and `lock_out`, so a wrong internal state shows up as an enable at the wrong time or a missing one. A state machine that skips or shortens settling raises `out_en` within the first `SETTLE_TICKS` strobes after the supply rises. A state machine that loses the waiting state after power-down fails to come back within a few cycles of `pd_n` returning high. A lock register that follows the PLL drops `lock_out` within `SYNC_STAGES` + 1 cycles of `pll_locked` falling. Each of these is sampled a fixed number of cycles after the stimulus. The settling bounds are taken with one strobe period of margin on each side.

// File: rtl/clkbuf_pwrup_pkg.sv
// Package: shared state encoding for the power-up sequencer.
package clkbuf_pwrup_pkg;

    // Sequencer states; order follows the power-up sequence.
    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_t;

    // Bit positions inside the synchronized input bundle.
    localparam int IDX_SUPPLY = 0;
    localparam int IDX_REF    = 1;
    localparam int IDX_PDN    = 2;
    localparam int IDX_PLL    = 3;
    localparam int IDX_BYP    = 4;
    localparam int NUM_IN     = 5;

endpackage

// File: rtl/clkbuf_pwrup_sync.sv
// Module: clkbuf_pwrup_sync
// Brings a bundle of asynchronous level inputs into the clk domain through
// a chain of STAGES flops per bit.
// Assumes: inputs are quasi-static levels; a pulse shorter than a clock
// period may be missed. Reset value of every stage is 0.
module clkbuf_pwrup_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    // Remaining stages: shift the captured value along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // Synchronizer must present the input STAGES cycles later.
    p_sync_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, STAGES) |-> sync_out == $past(async_in, STAGES))
        else $error("synchronizer latency broken");

endmodule

// File: rtl/clkbuf_pwrup_timer.sv
// Module: clkbuf_pwrup_timer
// Counts timebase strobes while enabled and flags the strobe that completes
// SETTLE_TICKS of them. Cleared whenever not enabled, so every entry into
// settling starts from zero.
// Assumes: SETTLE_TICKS >= 1; tick is a one-cycle strobe in the clk domain.
module clkbuf_pwrup_timer #(
    parameter int SETTLE_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam int CW   = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS);
    localparam int LAST = SETTLE_TICKS - 1;

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == CW'(LAST));
    assign done    = run && tick && at_last;

    // Strobe counter: clears when idle, advances on each strobe while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      cnt_q <= '0;
        else if (tick && !at_last) cnt_q <= cnt_q + 1'b1;
    end

    // Counter never passes the final count.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST))
        else $error("settle counter overflow");

    // An idle period always leaves the counter cleared.
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0)
        else $error("settle counter not cleared");

endmodule

// File: rtl/clkbuf_pwrup_fsm.sv
// Module: clkbuf_pwrup_fsm
// Four-state power-up sequencer with a sticky lock flag.
// Assumes: all level inputs are already synchronized; settle_done is a
// one-cycle flag from the settle timer, valid only while settling.
module clkbuf_pwrup_fsm
    import clkbuf_pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_s,
    input  logic       ref_s,
    input  logic       pdn_s,
    input  logic       pll_s,
    input  logic       byp_s,
    input  logic       settle_done,
    output logic       settling,
    output logic       en_q,
    output logic       lock_q
);

    seq_state_t state_q, state_d;
    logic       ready;
    logic       lock_clr;

    // PLL condition is waived in bypass; a reference clock is always needed.
    assign ready    = ref_s && pdn_s && (pll_s || byp_s);
    assign lock_clr = !supply_s || !pdn_s;
    assign settling = (state_q == SEQ_SETTLE);

    // Next-state decode; supply loss overrides everything.
    always_comb begin
        state_d = state_q;
        if (!supply_s) begin
            state_d = SEQ_OFF;
        end else begin
            unique case (state_q)
                SEQ_OFF:    state_d = SEQ_SETTLE;
                SEQ_SETTLE: if (settle_done) state_d = SEQ_WAIT;
                SEQ_WAIT:   if (ready)       state_d = SEQ_RUN;
                SEQ_RUN:    if (!pdn_s)      state_d = SEQ_WAIT;
                default:    state_d = SEQ_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    // Output-enable register: high exactly while the next state is running.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= (state_d == SEQ_RUN);
    end

    // Sticky lock flag: set on entering run, cleared only by power-down or supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n || lock_clr)          lock_q <= 1'b0;
        else if (state_d == SEQ_RUN)     lock_q <= 1'b1;
    end

    // Supply loss returns to power-off with everything cleared.
    p_supply_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_s |=> (state_q == SEQ_OFF) && !en_q && !lock_q)
        else $error("supply loss not honoured");

    // Waiting is reached only from settling on a completed delay, or from run.
    p_settle_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SETTLE) && supply_s && !settle_done |=> state_q == SEQ_SETTLE)
        else $error("left settling early");

    // Enable rises only when clock, power-down and lock/bypass conditions hold.
    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(ref_s && pdn_s && (pll_s || byp_s) && supply_s))
        else $error("enable without conditions");

    // Lock is never reported without enabled outputs.
    p_lock_implies_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> en_q)
        else $error("lock without enable");

    // Lock holds through PLL drop while supply and power-down allow it.
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && supply_s && pdn_s |=> lock_q)
        else $error("lock dropped");

    // Power-down while running goes back to waiting, not further.
    p_pd_to_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN) && supply_s && !pdn_s |=> state_q == SEQ_WAIT && !en_q)
        else $error("power-down handling wrong");

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
// Module: clkbuf_pwrup_seq (top)
// Power-up sequencer for a differential clock buffer: synchronizes the level
// inputs, times the settling delay in timebase strobes and runs the state
// machine that drives the output-enable and the latched lock flag.
// Assumes: tick is a one-cycle strobe in the clk domain; all other inputs
// may change at any time.
module clkbuf_pwrup_seq
    import clkbuf_pwrup_pkg::*;
#(
    parameter int SETTLE_TICKS = 250,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic ref_present,
    input  logic pd_n,
    input  logic pll_locked,
    input  logic bypass,
    output logic out_en,
    output logic lock_out
);

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;
    logic              settling;
    logic              settle_done;

    // Pack the asynchronous inputs into one bundle for the synchronizer.
    always_comb begin
        raw_in             = '0;
        raw_in[IDX_SUPPLY] = supply_ok;
        raw_in[IDX_REF]    = ref_present;
        raw_in[IDX_PDN]    = pd_n;
        raw_in[IDX_PLL]    = pll_locked;
        raw_in[IDX_BYP]    = bypass;
    end

    clkbuf_pwrup_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn_in)
    );

    clkbuf_pwrup_timer #(
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settling),
        .tick  (tick),
        .done  (settle_done)
    );

    clkbuf_pwrup_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_s    (syn_in[IDX_SUPPLY]),
        .ref_s       (syn_in[IDX_REF]),
        .pdn_s       (syn_in[IDX_PDN]),
        .pll_s       (syn_in[IDX_PLL]),
        .byp_s       (syn_in[IDX_BYP]),
        .settle_done (settle_done),
        .settling    (settling),
        .en_q        (out_en),
        .lock_q      (lock_out)
    );

    // Outputs are off in the cycle after any reset.
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> !out_en && !lock_out)
        else $error("outputs not cleared by reset");

endmodule

// File: tb/clkbuf_pwrup_seq_bench.sv
module clkbuf_pwrup_seq_bench;

    localparam int SETTLE = 4;
    localparam int TPER   = 8;   // clocks per timebase strobe
    localparam int NVEC   = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_ok = 1'b0, ref_present = 1'b0, pd_n = 1'b0;
    logic pll_locked = 1'b0, bypass = 1'b0;
    logic out_en, lock_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    clkbuf_pwrup_seq #(.SETTLE_TICKS(SETTLE), .SYNC_STAGES(2)) u_clkbuf_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .ref_present(ref_present), .pd_n(pd_n), .pll_locked(pll_locked),
        .bypass(bypass), .out_en(out_en), .lock_out(lock_out)
    );

    // Timebase strobe: one cycle high every TPER cycles.
    initial begin
        forever begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (TPER - 2) @(negedge clk);
        end
    end

    // Vector bits: supply, ref, pd_n, pll, bypass, expected en, expected lock.
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1_1_1_0_0_0_0,  // R3: no PLL lock, stay off
        7'b1_1_0_1_0_0_0,  // R3: power-down held
        7'b1_0_1_1_0_0_0,  // R4: clock absent
        7'b1_1_1_1_0_1_1,  // R3 R6: all good, enable and lock together
        7'b1_1_1_0_0_1_1,  // R7: PLL drops, lock sticky
        7'b1_1_0_0_0_0_0,  // R8: power-down clears
        7'b1_1_1_0_0_0_0,  // R8: released but no lock
        7'b1_1_1_1_0_1_1,  // R8: back without re-settle
        7'b1_1_0_1_0_0_0,  // R8: power-down again
        7'b1_0_1_0_1_0_0,  // R5: bypass without clock
        7'b1_1_1_0_1_1_1,  // R5: bypass with clock
        7'b0_1_1_1_1_0_0,  // R9: supply lost
        7'b1_1_1_1_1_0_0   // R9: supply back, must settle first
    };

    task automatic chk(input string req, input logic exp_en, input logic exp_lk);
        total++;
        if (out_en !== exp_en || lock_out !== exp_lk) begin
            bad++;
            $display("FAIL %s: en/lock actual=%b%b expected=%b%b at %0t",
                     req, out_en, lock_out, exp_en, exp_lk, $time);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        supply_ok   = v[6];
        ref_present = v[5];
        pd_n        = v[4];
        pll_locked  = v[3];
        bypass      = v[2];
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state.
        waitc(4);
        chk("R1 in reset", 1'b0, 1'b0);
        drive(7'b0_1_1_1_0_0_0);
        @(negedge clk) rst_n = 1'b1;
        waitc(6);
        chk("R1 after reset, no supply", 1'b0, 1'b0);

        // R2: supply up with everything ready, enable must wait for the delay.
        supply_ok = 1'b1;
        waitc((SETTLE - 1) * TPER);
        chk("R2 inside settle delay", 1'b0, 1'b0);
        waitc(2 * TPER + 4);
        chk("R2 enabled after settle", 1'b1, 1'b1);

        // R8: drop power-down to reach the waiting state for the table.
        pd_n = 1'b0;
        waitc(6);
        chk("R8 power-down from run", 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            waitc(6);
            chk($sformatf("R3-table step %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R9: after the last vector the sequencer settles again.
        waitc(3 * TPER + 12);
        chk("R9 resettled after supply return", 1'b1, 1'b1);

        // R9: supply drop during settling restarts the count.
        supply_ok = 1'b0;
        waitc(6);
        chk("R9 supply off", 1'b0, 1'b0);
        supply_ok = 1'b1;
        waitc(2 * TPER);
        supply_ok = 1'b0;
        waitc(6);
        supply_ok = 1'b1;
        waitc((SETTLE - 1) * TPER);
        chk("R9 restarted settle count", 1'b0, 1'b0);
        waitc(2 * TPER + 4);
        chk("R9 enabled after restarted settle", 1'b1, 1'b1);

        // R5: bypass drop with PLL unlocked while running keeps lock (R7 too).
        bypass = 1'b0;
        pll_locked = 1'b0;
        waitc(6);
        chk("R7 lock held after bypass/PLL change", 1'b1, 1'b1);

        // R1: reset mid-run clears outputs.
        @(negedge clk) rst_n = 1'b0;
        waitc(2);
        chk("R1 reset while running", 1'b0, 1'b0);
        rst_n = 1'b1;
        waitc(4);
        chk("R2 no enable right after reset", 1'b0, 1'b0);

        summary();
    end

endmodule